// File: doc/BRIEF.md
# Five-Way Fixed-Priority External Bus Arbiter

This block decides which of five masters drives a shared external bus for the next bus cycle. The masters are an outside device asking to take over the bus, a DMA engine, and three CPU paths: data operand accesses, instruction fetches after a branch, and straight-line instruction fetches. Each master raises its bit of a request vector and receives its bit of a one-hot grant vector. A new owner is chosen only at a bus-cycle boundary, and the grant is held until then.

The operand path also drives two sideband flags. The split lock keeps the bus with the operand path for all the pieces of one multi-access transfer, such as a misaligned word. The read-modify-write flag marks the gap between a read and its write-back. Only instruction fetches may use that gap; every other master waits for the write to finish. When the external device is granted, an acknowledge follows one clock later and stays up until the device lets go of its request.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While rst_n is low, gnt is 0 and hold_ack is 0, whatever the inputs are.
- R2: gnt has at most one bit set. When no request is pending at an arbitration point, gnt becomes 0.
- R3: With both flags low, the request bits rank by index, bit 0 highest: bit 0 external hold, bit 1 DMA, bit 2 operand, bit 3 branch fetch, bit 4 sequential fetch. The lowest set index is granted on the clock after an arbitration point.
- R4: A grant to a master other than bit 0 stays unchanged until cyc_done is sampled high. When gnt is 0, every clock is an arbitration point.
- R5: With both flags low, a set bit 0 at an arbitration point wins over every other request.
- R6: If op_lock and req[2] are both high at an arbitration point, the operand master is granted, even against the hold and DMA requests.
- R7: If op_rmw is high and op_lock is low at an arbitration point, the branch fetch wins, then the sequential fetch, then the operand master. Hold and DMA are not granted.
- R8: hold_ack rises one clock after gnt[0] if req[0] is still high. It stays high while req[0] is high, and it falls on the same clock edge as gnt[0].
- R9: The hold grant is released only when req[0] is sampled low. cyc_done has no effect while bit 0 owns the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 5 | Request vector, bit 0 hold, 1 DMA, 2 operand, 3 branch fetch, 4 sequential fetch |
| op_lock | input | 1 | Operand split-access lock |
| op_rmw | input | 1 | Operand read-modify-write gap flag |
| cyc_done | input | 1 | Current bus cycle completes this clock |
| gnt | output | 5 | One-hot grant, same bit order as req |
| hold_ack | output | 1 | Acknowledge to the external hold requester |

## Verification
A wrong owner register shows up on gnt on the clock after the next arbitration point. The usual signs are a second bit set, a grant that moves while cyc_done is low, or a lower-ranked master beating a higher one. A broken lock or gap path lets hold or DMA win in a cycle where the operand or a fetch should win, and this is visible at the next boundary. A faulty acknowledge shows up as hold_ack missing one clock after gnt[0], or as hold_ack lingering once gnt[0] has fallen.

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
  parameter int NREQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] req,
  input  logic            op_lock,
  input  logic            op_rmw,
  input  logic            cyc_done,
  output logic [NREQ-1:0] gnt,
  output logic            hold_ack
);
  localparam int HOLD = 0;
  localparam int DMA  = 1;
  localparam int OPND = 2;
  localparam int BFET = 3;
  localparam int SFET = 4;

  logic [NREQ-1:0] gnt_q, pick;
  logic            ack_q, arb;

  assign arb = (gnt_q == '0) || (gnt_q[HOLD] ? !req[HOLD] : cyc_done);

  always_comb begin
    pick = '0;
    if (op_lock && req[OPND])  pick[OPND] = 1'b1;
    else if (op_rmw) begin
      if (req[BFET])           pick[BFET] = 1'b1;
      else if (req[SFET])      pick[SFET] = 1'b1;
      else if (req[OPND])      pick[OPND] = 1'b1;
    end
    else if (req[HOLD])        pick[HOLD] = 1'b1;
    else if (req[DMA])         pick[DMA]  = 1'b1;
    else if (req[OPND])        pick[OPND] = 1'b1;
    else if (req[BFET])        pick[BFET] = 1'b1;
    else if (req[SFET])        pick[SFET] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      if (arb) gnt_q <= pick;
      ack_q <= gnt_q[HOLD] && req[HOLD];
    end
  end

  assign gnt      = gnt_q;
  assign hold_ack = ack_q;
endmodule

// File: rtl/ext_bus_arbiter_chk.sv
module ext_bus_arbiter_chk #(
  parameter int NREQ = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req,
  input logic            op_lock,
  input logic            op_rmw,
  input logic            cyc_done,
  input logic [NREQ-1:0] gnt,
  input logic            hold_ack
);
  logic boundary;
  assign boundary = (gnt == '0) || (gnt[0] ? !req[0] : cyc_done);

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !gnt[0] && !cyc_done) |=> $stable(gnt));

  // R5
  hold_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !op_lock && !op_rmw && req[0]) |=> gnt[0]);

  // R6
  split_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && op_lock && req[2]) |=> (gnt == 5'b00100));

  // R7
  rmw_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !op_lock && op_rmw) |=> (!gnt[0] && !gnt[1]));

  // R8
  ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gnt[0]) && req[0]) |=> hold_ack);

  // R8
  ack_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> gnt[0]);

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt[0] && req[0]) |=> gnt[0]);
endmodule

bind ext_bus_arbiter ext_bus_arbiter_chk #(.NREQ(NREQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .op_lock(op_lock), .op_rmw(op_rmw),
  .cyc_done(cyc_done), .gnt(gnt), .hold_ack(hold_ack)
);

// File: tb/tb_ext_bus_arbiter.sv
module tb_ext_bus_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] req = '0;
  logic       op_lock = 1'b0, op_rmw = 1'b0, cyc_done = 1'b0;
  logic [4:0] gnt;
  logic       hold_ack;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct { logic [4:0] g; logic a; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  ext_bus_arbiter dut (.clk(clk), .rst_n(rst_n), .req(req), .op_lock(op_lock),
    .op_rmw(op_rmw), .cyc_done(cyc_done), .gnt(gnt), .hold_ack(hold_ack));

  task automatic step(input logic [4:0] r, input logic lk, input logic rw,
                      input logic cd, input logic [4:0] eg, input logic ea,
                      input string tag);
    exp_t e;
    @(negedge clk);
    req = r; op_lock = lk; op_rmw = rw; cyc_done = cd;
    e.g = eg; e.a = ea; e.tag = tag;
    sb.push_back(e);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (gnt !== e.g || hold_ack !== e.a) begin
        failures++;
        $display("FAIL %s gnt=%b ack=%b expected gnt=%b ack=%b",
                 e.tag, gnt, hold_ack, e.g, e.a);
      end
    end
  end

  initial begin
    for (int c = 0; c < 10000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    req = 5'b11111; op_lock = 1'b1; cyc_done = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (gnt !== 5'b0 || hold_ack !== 1'b0) begin
      failures++;
      $display("FAIL R1 gnt=%b ack=%b expected gnt=00000 ack=0", gnt, hold_ack);
    end
    rst_n = 1'b1;
    req = '0; op_lock = 1'b0; cyc_done = 1'b0;

    step(5'b00000, 0, 0, 0, 5'b00000, 0, "R2 idle");
    step(5'b11110, 0, 0, 0, 5'b00010, 0, "R3 dma first");
    step(5'b11110, 0, 0, 0, 5'b00010, 0, "R4 held");
    step(5'b11111, 0, 0, 0, 5'b00010, 0, "R4 hold waits boundary");
    step(5'b11100, 0, 0, 1, 5'b00100, 0, "R3 operand");
    step(5'b11000, 0, 0, 1, 5'b01000, 0, "R3 branch fetch");
    step(5'b10000, 0, 0, 1, 5'b10000, 0, "R3 seq fetch");
    step(5'b00000, 0, 0, 1, 5'b00000, 0, "R2 release");

    step(5'b00001, 0, 0, 0, 5'b00001, 0, "R8 grant before ack");
    step(5'b00011, 0, 0, 1, 5'b00001, 1, "R9 done ignored");
    step(5'b00011, 0, 0, 1, 5'b00001, 1, "R8 ack held");
    step(5'b00010, 0, 0, 0, 5'b00010, 0, "R8 ack drops");
    step(5'b00000, 0, 0, 1, 5'b00000, 0, "R2 idle again");

    step(5'b00100, 1, 0, 0, 5'b00100, 0, "R6 lock start");
    step(5'b00111, 1, 0, 1, 5'b00100, 0, "R6 lock beats hold");
    step(5'b00111, 0, 0, 1, 5'b00001, 0, "R5 hold wins");
    step(5'b00000, 0, 0, 0, 5'b00000, 0, "R9 hold released");

    step(5'b00100, 0, 0, 0, 5'b00100, 0, "R7 rmw read");
    step(5'b11111, 0, 1, 1, 5'b01000, 0, "R7 branch in gap");
    step(5'b10111, 0, 1, 1, 5'b10000, 0, "R7 seq in gap");
    step(5'b00111, 0, 1, 1, 5'b00100, 0, "R7 write beats hold");
    step(5'b00011, 0, 0, 1, 5'b00001, 0, "R5 hold after rmw");
    step(5'b00010, 0, 0, 0, 5'b00010, 0, "R8 no ack on early drop");
    step(5'b00000, 0, 0, 1, 5'b00000, 0, "R2 final idle");

    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule